// File: doc/BRIEF.md
# Timer Event Interrupt Arbiter

This block sits beside a six-channel timer unit. It turns the timer's event strobes into flagged, prioritised interrupt requests and into DMA activation pulses. The timer reports events on plain pulse inputs: compare match and input capture per compare slot, overflow per channel, and underflow where a channel counts down. Each event sets a sticky status flag. Software reads the flags, writes a per-source enable mask, and clears flags by writing 0 to their bit positions.

The block presents the raw flags, the enable mask, and the pending vector (flag AND enable). It also gives the flat index of the highest-priority pending source and a valid bit. Two sources may start a DMA transfer: the first compare slot of channel 3 and the first compare slot of channel 4. Each gives a one-cycle request pulse when its flag rises while enabled. The matching acknowledge clears that flag.

Top module: `tmr_irq_arb`

## Requirements
- R1: `irq_o` bit i is 1 exactly when `flag_o` bit i and `en_o` bit i are both 1.
- R2: A cycle with `flag_wr_i`=1 clears every flag whose `flag_wdata_i` bit is 0 and leaves the flags whose bit is 1 unchanged. Apart from a DMA acknowledge, nothing else clears a flag.
- R3: When a set event and a clear (software write or DMA acknowledge) hit the same flag in one cycle, the flag ends up 1.
- R4: Flat source index, highest priority first. Channel 0: compare slots 0-5 on 0-5, overflow on 6. Channel 1: compare 7-8, overflow 9, underflow 10. Channel 2: compare 11-12, overflow 13, underflow 14. Channel 3: compare 15-18, overflow 19. Channel 4: compare 20-23, overflow/underflow 24. Channel 5: compare 25-27. Compare inputs `cmp_match_i`/`cap_evt_i` are numbered the same way without the non-compare sources: channel 0 bits 0-5, channel 1 bits 6-7, channel 2 bits 8-9, channel 3 bits 10-13, channel 4 bits 14-17, channel 5 bits 18-20.
- R5: Compare flags are set by either a compare match or a capture event on their slot. The exception is channel 0's fifth and sixth slots (compare bits 4 and 5), which ignore capture events.
- R6: `ovf_i` bit c sets channel c's overflow flag. `udf_i` bit 0 sets flag 10 and bit 1 sets flag 14. `udf_i` bit 2 sets flag 24, the same flag that channel 4's overflow sets.
- R7: `irq_valid_o` is 1 when any `irq_o` bit is 1. `irq_idx_o` then gives the lowest pending flat index. Both follow the current pending set with no added latency.
- R8: `dma_req_o` bit 0 (flag 15) and bit 1 (flag 20) each pulse for one cycle. The pulse comes in the same cycle the flag first reads 1, and only if that flag was 0 and its enable was 1 when the set event arrived.
- R9: `dma_ack_i` bit 0 clears flag 15 and bit 1 clears flag 20, unless a set event for that flag arrives in the same cycle.
- R10: No source other than flags 15 and 20 ever produces a DMA request.
- R11: After reset all flags, enables, pending bits, `irq_valid_o` and `dma_req_o` are 0.
- R12: A cycle with `en_wr_i`=1 loads the whole enable mask from `en_wdata_i`. Enables do not gate flag setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_match_i | input | 21 | Compare-match pulse per compare slot |
| cap_evt_i | input | 21 | Input-capture pulse per compare slot |
| ovf_i | input | 5 | Overflow strobe, channels 0-4 |
| udf_i | input | 3 | Underflow strobe: channel 1, channel 2, channel 4 |
| flag_wr_i | input | 1 | Flag write strobe (0 bits clear) |
| flag_wdata_i | input | 28 | Flag write data |
| en_wr_i | input | 1 | Enable mask write strobe |
| en_wdata_i | input | 28 | Enable mask write data |
| dma_ack_i | input | 2 | DMA acknowledge, clears the matching flag |
| flag_o | output | 28 | Status flags |
| en_o | output | 28 | Enable mask |
| irq_o | output | 28 | Pending requests |
| irq_valid_o | output | 1 | Any request pending |
| irq_idx_o | output | 5 | Flat index of the winning source |
| dma_req_o | output | 2 | DMA activation pulse |

## Verification
An event, a flag write, an enable write or an acknowledge applied in one cycle shows on `flag_o`/`en_o` after the next rising edge. `irq_o`, `irq_valid_o` and `irq_idx_o` follow in that same cycle, because they are combinational from the registers. A DMA pulse is visible in exactly that cycle and has gone one cycle later. The bench drives every stimulus just after a falling edge, holds it through one rising edge, and samples at the following falling edge. Each result is read in the cycle it is due. A second idle cycle confirms that the DMA pulse has ended.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    localparam int NCH       = 6;
    localparam int NOVF      = 5;
    localparam int NUDF      = 3;
    localparam int NDMA      = 2;
    localparam int CAP_SKIP0 = 4;   // channel 0 slots from here on ignore capture

    function automatic int ncmp(input int ch);
        case (ch)
            0:       return 6;
            1, 2:    return 2;
            3, 4:    return 4;
            default: return 3;
        endcase
    endfunction

    function automatic bit has_ovf(input int ch);
        return ch < NOVF;
    endfunction

    function automatic bit own_udf(input int ch);
        return (ch == 1) || (ch == 2);
    endfunction

    function automatic bit shared_udf(input int ch);
        return ch == 4;
    endfunction

    function automatic int udf_port(input int ch);
        case (ch)
            1:       return 0;
            2:       return 1;
            default: return 2;
        endcase
    endfunction

    function automatic int nsrc(input int ch);
        return ncmp(ch) + int'(has_ovf(ch)) + int'(own_udf(ch));
    endfunction

    function automatic int cmp_base(input int ch);
        int s = 0;
        for (int c = 0; c < ch; c++) s += ncmp(c);
        return s;
    endfunction

    function automatic int src_base(input int ch);
        int s = 0;
        for (int c = 0; c < ch; c++) s += nsrc(c);
        return s;
    endfunction

    localparam int NCMP = cmp_base(NCH);
    localparam int NSRC = src_base(NCH);
    localparam int IDXW = $clog2(NSRC);

    function automatic logic [NCMP-1:0] cap_mask();
        logic [NCMP-1:0] m = '1;
        for (int k = CAP_SKIP0; k < ncmp(0); k++) m[cmp_base(0) + k] = 1'b0;
        return m;
    endfunction

    // DMA-capable sources: first compare slot of channel 3, then of channel 4
    function automatic int dma_src(input int j);
        return src_base(3 + j);
    endfunction

    typedef struct packed {
        logic [NCMP-1:0] cmp;
        logic [NCMP-1:0] cap;
        logic [NOVF-1:0] ovf;
        logic [NUDF-1:0] udf;
    } evt_t;

    typedef struct packed {
        logic            flag_wr;
        logic [NSRC-1:0] flag_wdata;
        logic            en_wr;
        logic [NSRC-1:0] en_wdata;
    } sw_t;

    typedef struct packed {
        logic            valid;
        logic [IDXW-1:0] idx;
    } win_t;

endpackage

// File: rtl/tmr_irq_evmap.sv
module tmr_irq_evmap
    import tmr_irq_pkg::*;
(
    input  evt_t            ev_i,
    output logic [NSRC-1:0] set_o
);

    logic [NCMP-1:0] cmp_hit;

    assign cmp_hit = ev_i.cmp | (ev_i.cap & cap_mask());

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam int CB = cmp_base(ch);
        localparam int SB = src_base(ch);
        localparam int NC = ncmp(ch);

        for (genvar k = 0; k < NC; k++) begin : g_cmp
            assign set_o[SB + k] = cmp_hit[CB + k];
        end

        if (has_ovf(ch)) begin : g_ovf
            if (shared_udf(ch)) begin : g_shared
                assign set_o[SB + NC] = ev_i.ovf[ch] | ev_i.udf[udf_port(ch)];
            end else begin : g_plain
                assign set_o[SB + NC] = ev_i.ovf[ch];
            end
        end

        if (own_udf(ch)) begin : g_udf
            assign set_o[SB + NC + 1] = ev_i.udf[udf_port(ch)];
        end
    end

endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tmr_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_i,
    input  sw_t             sw_i,
    input  logic [NDMA-1:0] ack_i,
    output logic [NSRC-1:0] flag_o,
    output logic [NSRC-1:0] en_o,
    output logic [NDMA-1:0] dma_req_o
);

    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] sw_clr;
    logic [NSRC-1:0] ack_vec;
    logic [NDMA-1:0] dma_q;

    assign sw_clr = sw_i.flag_wr ? ~sw_i.flag_wdata : '0;

    always_comb begin
        ack_vec = '0;
        for (int j = 0; j < NDMA; j++) ack_vec[dma_src(j)] = ack_i[j];
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= set_i | (flag_q & ~(sw_clr | ack_vec));
    end

    always_ff @(posedge clk) begin
        if (rst)             en_q <= '0;
        else if (sw_i.en_wr) en_q <= sw_i.en_wdata;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        // R2
        flag_clr_src_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(flag_q[i]) |-> $past(sw_clr[i] | ack_vec[i]));
        // R3
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flag_q[i]);
    end

    for (genvar j = 0; j < NDMA; j++) begin : g_dma
        localparam int S = dma_src(j);

        always_ff @(posedge clk) begin
            if (rst) dma_q[j] <= 1'b0;
            else     dma_q[j] <= set_i[S] & ~flag_q[S] & en_q[S];
        end

        // R8
        dma_single_chk: assert property (@(posedge clk) disable iff (rst)
            dma_q[j] |=> !dma_q[j]);
        // R8
        dma_flag_chk: assert property (@(posedge clk) disable iff (rst)
            dma_q[j] |-> flag_q[S]);
    end

    assign flag_o    = flag_q;
    assign en_o      = en_q;
    assign dma_req_o = dma_q;

endmodule

// File: rtl/tmr_irq_prio.sv
module tmr_irq_prio
    import tmr_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] pend_i,
    output win_t            win_o
);

    logic [NSRC-1:0] below_w;

    always_comb begin
        win_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                win_o.valid = 1'b1;
                win_o.idx   = IDXW'(i);
            end
        end
    end

    assign below_w = (NSRC'(1) << win_o.idx) - NSRC'(1);

    // R7
    win_pend_chk: assert property (@(posedge clk) disable iff (rst)
        win_o.valid |-> pend_i[win_o.idx]);
    // R7
    win_first_chk: assert property (@(posedge clk) disable iff (rst)
        win_o.valid |-> ((pend_i & below_w) == '0));

endmodule

// File: rtl/tmr_irq_arb.sv
module tmr_irq_arb
    import tmr_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NCMP-1:0] cmp_match_i,
    input  logic [NCMP-1:0] cap_evt_i,
    input  logic [NOVF-1:0] ovf_i,
    input  logic [NUDF-1:0] udf_i,
    input  logic            flag_wr_i,
    input  logic [NSRC-1:0] flag_wdata_i,
    input  logic            en_wr_i,
    input  logic [NSRC-1:0] en_wdata_i,
    input  logic [NDMA-1:0] dma_ack_i,
    output logic [NSRC-1:0] flag_o,
    output logic [NSRC-1:0] en_o,
    output logic [NSRC-1:0] irq_o,
    output logic            irq_valid_o,
    output logic [IDXW-1:0] irq_idx_o,
    output logic [NDMA-1:0] dma_req_o
);

    evt_t            ev;
    sw_t             sw;
    logic [NSRC-1:0] set_w;
    logic [NSRC-1:0] flag_w;
    logic [NSRC-1:0] en_w;
    win_t            win;

    assign ev = '{cmp: cmp_match_i, cap: cap_evt_i, ovf: ovf_i, udf: udf_i};
    assign sw = '{flag_wr: flag_wr_i, flag_wdata: flag_wdata_i,
                  en_wr: en_wr_i, en_wdata: en_wdata_i};

    tmr_irq_evmap u_evmap (
        .ev_i  (ev),
        .set_o (set_w)
    );

    tmr_irq_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .set_i     (set_w),
        .sw_i      (sw),
        .ack_i     (dma_ack_i),
        .flag_o    (flag_w),
        .en_o      (en_w),
        .dma_req_o (dma_req_o)
    );

    assign irq_o = flag_w & en_w;

    tmr_irq_prio u_prio (
        .clk    (clk),
        .rst    (rst),
        .pend_i (irq_o),
        .win_o  (win)
    );

    assign flag_o      = flag_w;
    assign en_o        = en_w;
    assign irq_valid_o = win.valid;
    assign irq_idx_o   = win.idx;

endmodule

// File: tb/tmr_irq_arb_tb_top.sv
`timescale 1ns/1ps
module tmr_irq_arb_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [20:0] cmp_match_i, cap_evt_i;
    logic [4:0]  ovf_i;
    logic [2:0]  udf_i;
    logic        flag_wr_i, en_wr_i;
    logic [27:0] flag_wdata_i, en_wdata_i;
    logic [1:0]  dma_ack_i;
    logic [27:0] flag_o, en_o, irq_o;
    logic        irq_valid_o;
    logic [4:0]  irq_idx_o;
    logic [1:0]  dma_req_o;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    tmr_irq_arb dut_i (
        .clk (clk), .rst (rst),
        .cmp_match_i (cmp_match_i), .cap_evt_i (cap_evt_i),
        .ovf_i (ovf_i), .udf_i (udf_i),
        .flag_wr_i (flag_wr_i), .flag_wdata_i (flag_wdata_i),
        .en_wr_i (en_wr_i), .en_wdata_i (en_wdata_i),
        .dma_ack_i (dma_ack_i),
        .flag_o (flag_o), .en_o (en_o), .irq_o (irq_o),
        .irq_valid_o (irq_valid_o), .irq_idx_o (irq_idx_o),
        .dma_req_o (dma_req_o)
    );

    task automatic idle();
        cmp_match_i = '0; cap_evt_i = '0; ovf_i = '0; udf_i = '0;
        flag_wr_i = 1'b0; flag_wdata_i = '1;
        en_wr_i = 1'b0; en_wdata_i = '0; dma_ack_i = '0;
    endtask

    // inputs set just after a falling edge; one rising edge; sample at next falling edge
    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_all();
        flag_wr_i = 1'b1; flag_wdata_i = '0; tick();
    endtask

    task automatic t_reset();
        chk("R11", "flags", 32'(flag_o), 0);
        chk("R11", "enables", 32'(en_o), 0);
        chk("R11", "pending", 32'(irq_o), 0);
        chk("R11", "valid", 32'(irq_valid_o), 0);
        chk("R11", "dma", 32'(dma_req_o), 0);
    endtask

    task automatic t_capture();
        cap_evt_i[0] = 1'b1; tick();
        chk("R5", "capture sets ch0 slot A", 32'(flag_o), 32'h1);
        cap_evt_i[4] = 1'b1; cap_evt_i[5] = 1'b1; tick();
        chk("R5", "capture ignored on ch0 slots E,F", 32'(flag_o), 32'h1);
        cmp_match_i[5] = 1'b1; tick();
        chk("R5", "compare sets ch0 slot F", 32'(flag_o), 32'h21);
        cap_evt_i[20] = 1'b1; cap_evt_i[7] = 1'b1; tick();
        chk("R4", "ch5 C and ch1 B map", 32'(flag_o), 32'h21 | (32'h1 << 27) | (32'h1 << 8));
        clear_all();
        chk("R2", "clear all", 32'(flag_o), 0);
    endtask

    task automatic t_clear();
        cmp_match_i[0] = 1'b1; cmp_match_i[20] = 1'b1; tick();
        flag_wr_i = 1'b1; flag_wdata_i = ~28'h1; tick();
        chk("R2", "zero bit clears", 32'(flag_o), 32'h1 << 27);
        flag_wr_i = 1'b1; flag_wdata_i = '1; tick();
        chk("R2", "one bits keep", 32'(flag_o), 32'h1 << 27);
        clear_all();
    endtask

    task automatic t_set_wins();
        cmp_match_i[20] = 1'b1; tick();
        flag_wr_i = 1'b1; flag_wdata_i = '0; cmp_match_i[20] = 1'b1; tick();
        chk("R3", "set beats clear", 32'(flag_o), 32'h1 << 27);
        clear_all();
    endtask

    task automatic t_ovf_udf();
        ovf_i[4] = 1'b1; tick();
        chk("R6", "ch4 overflow", 32'(flag_o), 32'h1 << 24);
        clear_all();
        udf_i[2] = 1'b1; tick();
        chk("R6", "ch4 underflow shares flag", 32'(flag_o), 32'h1 << 24);
        clear_all();
        udf_i[0] = 1'b1; udf_i[1] = 1'b1; ovf_i[1] = 1'b1; ovf_i[0] = 1'b1; tick();
        chk("R6", "ch0/1 overflow, ch1/2 underflow", 32'(flag_o),
            (32'h1 << 6) | (32'h1 << 9) | (32'h1 << 10) | (32'h1 << 14));
        clear_all();
    endtask

    task automatic t_irq();
        en_wr_i = 1'b1; en_wdata_i = 28'h208; tick();
        chk("R12", "enable load", 32'(en_o), 32'h208);
        chk("R1", "no flag no request", 32'(irq_o), 0);
        cmp_match_i[2] = 1'b1; cmp_match_i[3] = 1'b1; tick();
        chk("R12", "disabled flag still sets", 32'(flag_o), 32'hC);
        chk("R1", "pending = flag & enable", 32'(irq_o), 32'h8);
        chk("R7", "winner idx", {26'd0, irq_valid_o, irq_idx_o}, {26'd0, 1'b1, 5'd3});
        flag_wr_i = 1'b1; flag_wdata_i = ~28'h8; tick();
        chk("R1", "cleared flag drops request", 32'(irq_o), 0);
        chk("R7", "no valid", 32'(irq_valid_o), 0);
        clear_all();
        en_wr_i = 1'b1; en_wdata_i = '0; tick();
    endtask

    task automatic t_prio();
        en_wr_i = 1'b1; en_wdata_i = '1; tick();
        cmp_match_i[20] = 1'b1; ovf_i[4] = 1'b1; cmp_match_i[11] = 1'b1; tick();
        chk("R7", "ch3 B first", {26'd0, irq_valid_o, irq_idx_o}, {26'd0, 1'b1, 5'd16});
        flag_wr_i = 1'b1; flag_wdata_i = ~(28'h1 << 16); tick();
        chk("R7", "ch4 ovf next", {26'd0, irq_valid_o, irq_idx_o}, {26'd0, 1'b1, 5'd24});
        flag_wr_i = 1'b1; flag_wdata_i = ~(28'h1 << 24); tick();
        chk("R7", "ch5 C last", {26'd0, irq_valid_o, irq_idx_o}, {26'd0, 1'b1, 5'd27});
        cmp_match_i[0] = 1'b1; tick();
        chk("R7", "ch0 A top", {26'd0, irq_valid_o, irq_idx_o}, {26'd0, 1'b1, 5'd0});
        en_wr_i = 1'b1; en_wdata_i = '0; tick();
        chk("R7", "disabled -> none", 32'(irq_valid_o), 0);
        clear_all();
    endtask

    task automatic t_dma();
        en_wr_i = 1'b1; en_wdata_i = (28'h1 << 15) | (28'h1 << 20) | (28'h1 << 16) | (28'h1 << 25);
        tick();
        cmp_match_i[10] = 1'b1; tick();
        chk("R8", "ch3 A pulse", 32'(dma_req_o), 32'h1);
        chk("R8", "flag with pulse", 32'(flag_o[15]), 1);
        tick();
        chk("R8", "pulse one cycle", 32'(dma_req_o), 0);
        cmp_match_i[10] = 1'b1; tick();
        chk("R8", "no pulse on set flag", 32'(dma_req_o), 0);
        dma_ack_i[0] = 1'b1; tick();
        chk("R9", "ack clears", 32'(flag_o[15]), 0);
        cmp_match_i[14] = 1'b1; tick();
        chk("R8", "ch4 A pulse", 32'(dma_req_o), 32'h2);
        dma_ack_i[1] = 1'b1; cmp_match_i[14] = 1'b1; tick();
        chk("R9", "set beats ack", 32'(flag_o[20]), 1);
        chk("R8", "no repeat pulse", 32'(dma_req_o), 0);
        cmp_match_i[11] = 1'b1; cmp_match_i[18] = 1'b1; ovf_i[3] = 1'b1; tick();
        chk("R10", "other sources no dma", 32'(dma_req_o), 0);
        clear_all();
        en_wr_i = 1'b1; en_wdata_i = '0; tick();
        cmp_match_i[10] = 1'b1; tick();
        chk("R8", "disabled no pulse", 32'(dma_req_o), 0);
        chk("R8", "disabled flag sets", 32'(flag_o[15]), 1);
        clear_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #100000;
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_capture();
        t_clear();
        t_set_wins();
        t_ovf_udf();
        t_irq();
        t_prio();
        t_dma();
        finish_run();
    end

endmodule